// File: doc/BRIEF.md
# Receive Interface Output Formatter

This block sits at the end of a receive channel. It takes one received word per clock and drives it onto a parallel receive bus. The word arrives in two forms at once: a decoded byte with its status flags (control character, error, valid, comma), and the raw 10-bit code group it came from. Two static select inputs choose what the bus carries. The first select picks byte content or raw 10-bit content. The second picks a full-width bus at single data rate, or a reduced-width bus at double data rate.

In the raw 10-bit modes no decoding is applied. The error and data-valid pins carry the two top bits of the code group. In the reduced-width modes only the low four data lines are used, and each word is split into two halves. The lower half is launched on the rising edge of the clock and the upper half on the falling edge. In raw reduced mode the data-valid pin carries the top bit of each five-bit half. The select inputs are captured together with the word, so a change of format always takes effect at a word boundary.

Top module: `rx_out_formatter`

## Requirements
- R1: While `rst` is high, every output is 0, including within the half cycle in which reset is raised. After a rising edge with `rst` high, both halves of the next word are 0 until a new word is captured.
- R2: Full byte mode (`raw_mode`=0, `narrow_mode`=0): `rx_data`=`dec_byte`, `rx_err`=`dec_err`, `rx_dv`=`dec_valid`, `rx_k`=`dec_k`.
- R3: Full raw mode (`raw_mode`=1, `narrow_mode`=0): `rx_data`=`code_grp[7:0]`, `rx_err`=`code_grp[9]`, `rx_dv`=`code_grp[8]`, and `rx_k` is 0.
- R4: In both reduced modes (`narrow_mode`=1), `rx_data[7:4]` is 0 in both half cycles.
- R5: Reduced raw mode, lower half: `rx_data[3:0]`=`code_grp[3:0]`, `rx_dv`=`code_grp[4]`, and `rx_err` and `rx_k` are 0.
- R6: Reduced raw mode, upper half: `rx_data[3:0]`=`code_grp[8:5]`, `rx_dv`=`code_grp[9]`, and `rx_err` and `rx_k` are 0.
- R7: Reduced byte mode: the lower half carries `dec_byte[3:0]` and the upper half carries `dec_byte[7:4]` on `rx_data[3:0]`. `rx_err`, `rx_dv` and `rx_k` carry the word's flags in both halves.
- R8: Inputs are sampled at a rising edge. The full word, or the lower half, appears after that edge. The upper half appears after the following falling edge and holds until the next rising edge. In full modes the word holds for the whole cycle.
- R9: The selects are sampled with the word. A change of `raw_mode` or `narrow_mode` between a rising edge and the next falling edge does not alter the upper half of the word in flight. The change applies from the next rising edge.
- R10: `rx_comma` equals the word's `comma_det` in every mode and in both halves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock; both edges are used |
| rst | input | 1 | Synchronous active-high reset; also forces outputs to 0 |
| raw_mode | input | 1 | 1 selects raw 10-bit content, 0 selects decoded byte content |
| narrow_mode | input | 1 | 1 selects the reduced-width double data rate bus |
| dec_byte | input | 8 | Decoded data byte |
| dec_k | input | 1 | Decoded word is a control character |
| dec_err | input | 1 | Decode error for this word |
| dec_valid | input | 1 | Word carries valid data |
| comma_det | input | 1 | Comma detected in this code group |
| code_grp | input | 10 | Raw received code group |
| rx_data | output | 8 | Receive data lines |
| rx_err | output | 1 | Error flag, or code bit 9 in full raw mode |
| rx_dv | output | 1 | Data-valid flag, or a code bit in raw modes |
| rx_comma | output | 1 | Comma flag |
| rx_k | output | 1 | Control character flag |

## Verification
A word applied before rising edge P is due on the bus just after P: the full word, or the lower half in reduced modes. The upper half is due just after the falling edge that follows P. The bench therefore reads the lower half 2 ns after P and the upper half 2 ns after that falling edge. It then applies the next word before the next rising edge. Reset gating acts without a clock, so raising reset in the upper half is checked 1 ns later. The select-change case alters the selects 1 ns after the lower-half read and expects the old format on the upper half and the new one after the next rising edge.

// File: rtl/rx_fmt_pkg.sv
package rx_fmt_pkg;

    localparam int CODE_W = 10;
    localparam int BYTE_W = 8;
    localparam int LINE_W = 8;
    localparam int HALF_W = LINE_W / 2;
    localparam int CODE_HALF = CODE_W / 2;

    typedef enum logic [1:0] {
        FMT_BYTE        = 2'b00,
        FMT_RAW         = 2'b01,
        FMT_BYTE_NARROW = 2'b10,
        FMT_RAW_NARROW  = 2'b11
    } fmt_mode_e;

    typedef struct packed {
        logic [BYTE_W-1:0] byte_d;
        logic              kflag;
        logic              errflag;
        logic              valid;
        logic              comma;
        logic [CODE_W-1:0] code;
    } rx_word_t;

    typedef struct packed {
        logic [LINE_W-1:0] lines;
        logic              err;
        logic              dv;
        logic              comma;
        logic              kchar;
    } pins_t;

    function automatic fmt_mode_e make_mode(logic raw_sel, logic narrow_sel);
        return fmt_mode_e'({narrow_sel, raw_sel});
    endfunction

    function automatic logic is_narrow(fmt_mode_e m);
        return (m == FMT_BYTE_NARROW) || (m == FMT_RAW_NARROW);
    endfunction

    function automatic logic is_raw(fmt_mode_e m);
        return (m == FMT_RAW) || (m == FMT_RAW_NARROW);
    endfunction

    // Pin pattern for one half of a word; full modes give the same pattern for both halves.
    function automatic pins_t map_pins(fmt_mode_e m, rx_word_t w, logic upper);
        pins_t p;
        p       = '0;
        p.comma = w.comma;
        unique case (m)
            FMT_BYTE: begin
                p.lines = w.byte_d;
                p.err   = w.errflag;
                p.dv    = w.valid;
                p.kchar = w.kflag;
            end
            FMT_RAW: begin
                p.lines = w.code[LINE_W-1:0];
                p.err   = w.code[CODE_W-1];
                p.dv    = w.code[CODE_W-2];
            end
            FMT_BYTE_NARROW: begin
                p.lines[HALF_W-1:0] = upper ? w.byte_d[BYTE_W-1:HALF_W]
                                            : w.byte_d[HALF_W-1:0];
                p.err   = w.errflag;
                p.dv    = w.valid;
                p.kchar = w.kflag;
            end
            default: begin
                p.lines[HALF_W-1:0] = upper ? w.code[CODE_W-2:CODE_HALF]
                                            : w.code[HALF_W-1:0];
                p.dv    = upper ? w.code[CODE_W-1] : w.code[CODE_HALF-1];
            end
        endcase
        return p;
    endfunction

endpackage

// File: rtl/rx_fmt_capture.sv
module rx_fmt_capture
    import rx_fmt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  fmt_mode_e mode_in,
    input  rx_word_t  word_in,
    output fmt_mode_e cap_mode,
    output pins_t     lo_q,
    output pins_t     hi_q,
    output logic      pos_tog
);

    pins_t lo_d;
    pins_t hi_d;

    always_comb begin
        lo_d = map_pins(mode_in, word_in, 1'b0);
        hi_d = map_pins(mode_in, word_in, 1'b1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_mode <= FMT_BYTE;
            lo_q     <= '0;
            hi_q     <= '0;
            pos_tog  <= 1'b0;
        end else begin
            cap_mode <= mode_in;
            lo_q     <= lo_d;
            hi_q     <= hi_d;
            pos_tog  <= ~pos_tog;
        end
    end

    // R1: a rising edge in reset leaves both halves cleared
    a_r1_capture_cleared: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (lo_q == '0 && hi_q == '0));

    // R4: reduced modes keep the upper data lines idle in both halves
    a_r4_upper_lines_idle: assert property (@(posedge clk) disable iff (rst)
        is_narrow(cap_mode) |-> (lo_q.lines[LINE_W-1:HALF_W] == '0 &&
                                 hi_q.lines[LINE_W-1:HALF_W] == '0));

    // R3: raw modes never flag a control character
    a_r3_no_k_raw: assert property (@(posedge clk) disable iff (rst)
        is_raw(cap_mode) |-> (!lo_q.kchar && !hi_q.kchar));

    // R5, R6: reduced raw mode keeps the error pin low in both halves
    a_r5_narrow_raw_err_low: assert property (@(posedge clk) disable iff (rst)
        (cap_mode == FMT_RAW_NARROW) |-> (!lo_q.err && !hi_q.err));

endmodule

// File: rtl/rx_fmt_fall_stage.sv
module rx_fmt_fall_stage
    import rx_fmt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  pins_t hi_in,
    input  logic  pos_tog,
    output pins_t hi_q,
    output logic  neg_tog
);

    always_ff @(negedge clk) begin
        if (rst) begin
            hi_q    <= '0;
            neg_tog <= 1'b0;
        end else begin
            hi_q    <= hi_in;
            neg_tog <= pos_tog;
        end
    end

    // R8: the half launched on a falling edge is the one captured at the rising edge before it
    a_r8_upper_launch: assert property (@(negedge clk) disable iff (rst)
        1'b1 |=> (hi_q == $past(hi_in)));

endmodule

// File: rtl/rx_out_formatter.sv
module rx_out_formatter
    import rx_fmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              raw_mode,
    input  logic              narrow_mode,
    input  logic [BYTE_W-1:0] dec_byte,
    input  logic              dec_k,
    input  logic              dec_err,
    input  logic              dec_valid,
    input  logic              comma_det,
    input  logic [CODE_W-1:0] code_grp,
    output logic [LINE_W-1:0] rx_data,
    output logic              rx_err,
    output logic              rx_dv,
    output logic              rx_comma,
    output logic              rx_k
);

    rx_word_t  word_in;
    fmt_mode_e mode_in;
    fmt_mode_e cap_mode;
    pins_t     lo_q;
    pins_t     hi_rise_q;
    pins_t     hi_fall_q;
    pins_t     pins_sel;
    pins_t     pins_out;
    logic      pos_tog;
    logic      neg_tog;
    logic      upper_phase;

    always_comb begin
        mode_in         = make_mode(raw_mode, narrow_mode);
        word_in.byte_d  = dec_byte;
        word_in.kflag   = dec_k;
        word_in.errflag = dec_err;
        word_in.valid   = dec_valid;
        word_in.comma   = comma_det;
        word_in.code    = code_grp;
    end

    rx_fmt_capture u_capture (
        .clk      (clk),
        .rst      (rst),
        .mode_in  (mode_in),
        .word_in  (word_in),
        .cap_mode (cap_mode),
        .lo_q     (lo_q),
        .hi_q     (hi_rise_q),
        .pos_tog  (pos_tog)
    );

    rx_fmt_fall_stage u_fall (
        .clk     (clk),
        .rst     (rst),
        .hi_in   (hi_rise_q),
        .pos_tog (pos_tog),
        .hi_q    (hi_fall_q),
        .neg_tog (neg_tog)
    );

    // Toggles agree once the falling edge has copied the rising-edge toggle.
    always_comb begin
        upper_phase = (pos_tog == neg_tog);
        pins_sel    = upper_phase ? hi_fall_q : lo_q;
        pins_out    = rst ? '0 : pins_sel;
        rx_data     = pins_out.lines;
        rx_err      = pins_out.err;
        rx_dv       = pins_out.dv;
        rx_comma    = pins_out.comma;
        rx_k        = pins_out.kchar;
    end

    // R8: full modes show the same pattern in both halves of the word
    a_r8_full_steady: assert property (@(posedge clk) disable iff (rst)
        (!is_narrow(cap_mode) && !$past(rst)) |-> (lo_q == hi_rise_q));

endmodule

// File: tb/rx_out_formatter_test.sv
module rx_out_formatter_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       raw_mode = 1'b0;
    logic       narrow_mode = 1'b0;
    logic [7:0] dec_byte = 8'h5A;
    logic       dec_k = 1'b1;
    logic       dec_err = 1'b1;
    logic       dec_valid = 1'b1;
    logic       comma_det = 1'b1;
    logic [9:0] code_grp = 10'h3FF;
    logic [7:0] rx_data;
    logic       rx_err;
    logic       rx_dv;
    logic       rx_comma;
    logic       rx_k;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #5 clk = ~clk;

    rx_out_formatter uut (
        .clk(clk), .rst(rst), .raw_mode(raw_mode), .narrow_mode(narrow_mode),
        .dec_byte(dec_byte), .dec_k(dec_k), .dec_err(dec_err), .dec_valid(dec_valid),
        .comma_det(comma_det), .code_grp(code_grp),
        .rx_data(rx_data), .rx_err(rx_err), .rx_dv(rx_dv), .rx_comma(rx_comma), .rx_k(rx_k)
    );

    // Expected {data, err, dv, comma, k} built from the requirement text.
    function automatic logic [11:0] expect_pins(bit raw, bit nar, bit up, logic [7:0] b,
                                                logic k, logic e, logic v, logic c,
                                                logic [9:0] cg);
        logic [7:0] d;
        logic ee, vv, kk;
        d = 8'h00; ee = 1'b0; vv = 1'b0; kk = 1'b0;
        if (!nar && !raw) begin
            d = b; ee = e; vv = v; kk = k;
        end else if (!nar && raw) begin
            d = cg[7:0]; ee = cg[9]; vv = cg[8];
        end else if (nar && !raw) begin
            d[3:0] = up ? b[7:4] : b[3:0];
            ee = e; vv = v; kk = k;
        end else begin
            if (up) begin
                d[3:0] = {cg[8], cg[7], cg[6], cg[5]};
                vv = cg[9];
            end else begin
                d[3:0] = cg[3:0];
                vv = cg[4];
            end
        end
        return {d, ee, vv, c, kk};
    endfunction

    function automatic logic [11:0] seen();
        return {rx_data, rx_err, rx_dv, rx_comma, rx_k};
    endfunction

    task automatic check(string tag, logic [11:0] act, logic [11:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%03h expected=%03h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic apply(bit raw, bit nar, logic [7:0] b, logic k, logic e, logic v,
                         logic c, logic [9:0] cg);
        raw_mode = raw; narrow_mode = nar; dec_byte = b; dec_k = k; dec_err = e;
        dec_valid = v; comma_det = c; code_grp = cg;
    endtask

    // Drive one word, read lower half 2 ns after the rising edge, upper half 2 ns after the falling edge.
    task automatic run_word(bit raw, bit nar, logic [7:0] b, logic k, logic e, logic v,
                            logic c, logic [9:0] cg);
        string tlo, thi;
        if (!nar) begin tlo = raw ? "R3" : "R2"; thi = "R8"; end
        else begin tlo = raw ? "R5" : "R7"; thi = raw ? "R6" : "R7"; end
        apply(raw, nar, b, k, e, v, c, cg);
        @(posedge clk); #2;
        check(tlo, seen(), expect_pins(raw, nar, 1'b0, b, k, e, v, c, cg));
        if (nar) check("R4", {4'h0, rx_data[7:4]}, 8'h00);
        @(negedge clk); #2;
        check(thi, seen(), expect_pins(raw, nar, 1'b1, b, k, e, v, c, cg));
        check("R10", {11'h0, rx_comma}, {11'h0, c});
        if (nar) check("R4", {4'h0, rx_data[7:4]}, 8'h00);
    endtask

    initial begin
        // R1: outputs zero during reset, in both halves of the cycle
        repeat (2) @(posedge clk);
        #2 check("R1", seen(), 12'h000);
        @(negedge clk); #2 check("R1", seen(), 12'h000);
        @(posedge clk); #2 rst = 1'b0;
        check("R1", seen(), 12'h000);
        @(negedge clk); #2;

        for (int m = 0; m < 4; m++) begin
            run_word(m[0], m[1], 8'hA5, 1'b0, 1'b1, 1'b1, 1'b0, 10'h17C);
            run_word(m[0], m[1], 8'h3C, 1'b1, 1'b0, 1'b1, 1'b1, 10'h283);
            run_word(m[0], m[1], 8'hFF, 1'b1, 1'b1, 1'b0, 1'b0, 10'h3FF);
            run_word(m[0], m[1], 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 10'h000);
            run_word(m[0], m[1], 8'h96, 1'b0, 1'b1, 1'b1, 1'b1, 10'h2AA);
            run_word(m[0], m[1], 8'h69, 1'b1, 1'b0, 1'b0, 1'b0, 10'h155);
        end
        // R5/R6: single bits walked through the raw code group in reduced mode
        for (int i = 0; i < 10; i++)
            run_word(1'b1, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 10'(1 << i));

        // R9: selects change after the lower half; the upper half keeps the old format
        apply(1'b1, 1'b1, 8'hC3, 1'b1, 1'b1, 1'b1, 1'b0, 10'h2D6);
        @(posedge clk); #2;
        check("R9", seen(), expect_pins(1'b1, 1'b1, 1'b0, 8'hC3, 1'b1, 1'b1, 1'b1, 1'b0, 10'h2D6));
        #1 apply(1'b0, 1'b0, 8'h7E, 1'b1, 1'b0, 1'b1, 1'b1, 10'h0F0);
        @(negedge clk); #2;
        check("R9", seen(), expect_pins(1'b1, 1'b1, 1'b1, 8'hC3, 1'b1, 1'b1, 1'b1, 1'b0, 10'h2D6));
        @(posedge clk); #2;
        check("R9", seen(), expect_pins(1'b0, 1'b0, 1'b0, 8'h7E, 1'b1, 1'b0, 1'b1, 1'b1, 10'h0F0));
        @(negedge clk); #2;

        // R1: reset raised in the upper half clears the outputs at once
        apply(1'b0, 1'b1, 8'hDB, 1'b1, 1'b1, 1'b1, 1'b1, 10'h3E7);
        @(posedge clk); #2;
        @(negedge clk); #2;
        rst = 1'b1;
        #1 check("R1", seen(), 12'h000);
        @(posedge clk); #2 check("R1", seen(), 12'h000);
        @(negedge clk); #2 check("R1", seen(), 12'h000);
        rst = 1'b0;
        run_word(1'b0, 1'b1, 8'hB4, 1'b0, 1'b1, 1'b1, 1'b1, 10'h1B4);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired before the run ended");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule